// File: doc/BRIEF.md
# Multiprocessor-Format Serial Transmitter

This block is an asynchronous serial transmitter whose frames carry one extra flag bit, the multiprocessor bit, placed after the data bits and before the stop bits. It has two storage stages. The first is a one-entry holding register that stores a data byte and a flag-bit value, together with an empty flag that works the other way round from the usual convention: when the flag reads 0, new data is waiting. The second is a shift stage that drives the serial line. A separate baud-rate tick input sets the bit time, and every bit lasts exactly one tick period.

The host writes a byte and a flag value. It then pulses the clear strobe, which drops the empty flag. The block copies the holding register into the shift stage, sets the empty flag to 1 again and sends the frame. The block looks at the empty flag at the tick where the first stop bit begins. If new data is waiting, it loads that data and starts the next frame as soon as the last stop bit ends. If nothing is waiting, it raises the transmit-end flag and leaves the line at mark. Two level outputs request service: one when the holding register is empty, one when transmission has ended. Each is gated by its own enable.

Top module: `mptx_top`

## Requirements
- R1: After reset, `empty_o` = 1, `tend_o` = 1 and `txd_o` = 1. The line stays at 1 while no frame is in progress.
- R2: Each frame is sent in this order. First one start bit of 0. Then the data bits, least significant first. Then the multiprocessor bit. Then the stop bits, each a 1. Every bit holds for one baud-tick period, and the line changes only on the clock edge where `baud_tick_i` = 1.
- R3: With `seven_bit_i` = 1, only data bits 0 to 6 are sent, and the multiprocessor bit comes straight after bit 6. Bit 7 of the written byte does not reach the line.
- R4: With `two_stop_i` = 1, two stop bits are sent. With `two_stop_i` = 0, one stop bit is sent.
- R5: The effective empty flag is the stored flag AND NOT `clr_empty_i`. While the line is idle, a clock edge on which the effective flag is 0 loads the shift stage and sets `empty_o` to 1 from the next cycle. The start bit then begins at the first baud tick after that edge.
- R6: At the baud tick where the first stop bit begins, the block checks the effective empty flag. If it is 0, the block loads the waiting data, and the next start bit follows the last stop bit with no mark bit between them. A clear strobe on that same clock edge counts as waiting data.
- R7: If the effective empty flag is 1 at that check, `tend_o` becomes 1 from the next cycle. The line holds at mark after the stop bits. A clear that arrives after the check starts the next frame after exactly one mark bit.
- R8: `clr_empty_i` clears `tend_o` on the next cycle.
- R9: The data and the multiprocessor bit are captured when the shift stage is loaded. Writes to the holding register after that load do not change the frame in progress.
- R10: `txi_o` equals `empty_o` AND `txi_en_i`, and `tei_o` equals `tend_o` AND `tei_en_i`. Both are level signals and follow their enables in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| baud_tick_i | input | 1 | One-cycle pulse per bit time |
| seven_bit_i | input | 1 | 1 selects 7 data bits, 0 selects 8 |
| two_stop_i | input | 1 | 1 selects two stop bits |
| wr_data_i | input | 1 | Write strobe for the holding register |
| wr_byte_i | input | DATA_W | Data byte to store |
| wr_mpb_i | input | 1 | Multiprocessor bit value to store |
| clr_empty_i | input | 1 | Clears the empty flag and the transmit-end flag |
| txi_en_i | input | 1 | Enables the empty request |
| tei_en_i | input | 1 | Enables the transmit-end request |
| txd_o | output | 1 | Serial line, idles at 1 |
| empty_o | output | 1 | 1 = holding register empty, 0 = data waiting |
| tend_o | output | 1 | Transmit-end flag |
| txi_o | output | 1 | Empty request (level) |
| tei_o | output | 1 | Transmit-end request (level) |

## Verification
Two events can land on the same clock edge: the host's clear strobe, and the stop-bit check that decides between chaining the next frame and ending transmission. The bench times the clear by counting the bits it has captured from the line, so that the strobe sits exactly on the tick that ends the multiprocessor bit. In that case the bench expects no gap between frames, the new data in the second frame, and `tend_o` staying at 0. The same sequence is then run with the clear one cycle late. That run must show `tend_o` rising, the transmit-end request following its enable, and exactly one mark bit before the second frame.

// File: rtl/mptx_pkg.sv
package mptx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PEND,
    ST_START,
    ST_DATA,
    ST_MPB,
    ST_STOP
  } tx_state_e;
endpackage

// File: rtl/mptx_hold.sv
module mptx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_data_i,
  input  logic [DATA_W-1:0] wr_byte_i,
  input  logic              wr_mpb_i,
  input  logic              clr_empty_i,
  input  logic              load_i,
  input  logic              miss_i,
  output logic              eff_empty_o,
  output logic [DATA_W-1:0] fwd_byte_o,
  output logic              fwd_mpb_o,
  output logic              empty_o,
  output logic              tend_o
);
  logic [DATA_W-1:0] byte_q;
  logic              mpb_q;
  logic              empty_q;
  logic              tend_q;

  // a clear in this cycle counts as data present; a write in this cycle is forwarded
  assign eff_empty_o = empty_q & ~clr_empty_i;
  assign fwd_byte_o  = wr_data_i ? wr_byte_i : byte_q;
  assign fwd_mpb_o   = wr_data_i ? wr_mpb_i  : mpb_q;
  assign empty_o     = empty_q;
  assign tend_o      = tend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_q <= '0;
      mpb_q  <= 1'b0;
    end else if (wr_data_i) begin
      byte_q <= wr_byte_i;
      mpb_q  <= wr_mpb_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          empty_q <= 1'b1;
    else if (load_i)      empty_q <= 1'b1;
    else if (clr_empty_i) empty_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          tend_q <= 1'b1;
    else if (miss_i)      tend_q <= 1'b1;
    else if (clr_empty_i) tend_q <= 1'b0;
  end

  a_r5_load_sets_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> empty_q);
  a_r5_empty_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !clr_empty_i) |=> $stable(empty_q));
  a_r7_miss_sets_tend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_i |=> tend_q);
  a_r8_clr_clears_tend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_empty_i && !miss_i) |=> !tend_q);
endmodule

// File: rtl/mptx_shift.sv
module mptx_shift
  import mptx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              baud_tick_i,
  input  logic              seven_bit_i,
  input  logic              two_stop_i,
  input  logic              eff_empty_i,
  input  logic [DATA_W-1:0] ld_byte_i,
  input  logic              ld_mpb_i,
  output logic              load_o,
  output logic              miss_o,
  output logic              txd_o
);
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  tx_state_e         state_q;
  logic [DATA_W-1:0] sh_q;
  logic              mpb_q;
  logic [IDX_W-1:0]  idx_q;
  logic              stop_cnt_q;
  logic              chain_q;
  logic [IDX_W-1:0]  last_idx;
  logic              last_stop;
  logic              check;

  assign last_idx  = seven_bit_i ? IDX_W'(DATA_W-2) : IDX_W'(DATA_W-1);
  assign last_stop = two_stop_i;
  // stop-bit check happens on the tick that ends the flag bit
  assign check     = (state_q == ST_MPB) && baud_tick_i;
  assign load_o    = !eff_empty_i && ((state_q == ST_IDLE) || check);
  assign miss_o    = check && eff_empty_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      mpb_q <= 1'b0;
    end else if (load_o) begin
      sh_q  <= ld_byte_i;
      mpb_q <= ld_mpb_i;
    end else if (state_q == ST_DATA && baud_tick_i) begin
      sh_q  <= {1'b0, sh_q[DATA_W-1:1]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      idx_q      <= '0;
      stop_cnt_q <= 1'b0;
      chain_q    <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE:  if (load_o) state_q <= ST_PEND;
        ST_PEND:  if (baud_tick_i) state_q <= ST_START;
        ST_START: if (baud_tick_i) begin
          state_q <= ST_DATA;
          idx_q   <= '0;
        end
        ST_DATA:  if (baud_tick_i) begin
          if (idx_q == last_idx) state_q <= ST_MPB;
          else                   idx_q   <= idx_q + 1'b1;
        end
        ST_MPB:   if (baud_tick_i) begin
          state_q    <= ST_STOP;
          stop_cnt_q <= 1'b0;
          chain_q    <= !eff_empty_i;
        end
        ST_STOP:  if (baud_tick_i) begin
          if (stop_cnt_q == last_stop) state_q <= chain_q ? ST_START : ST_IDLE;
          else                         stop_cnt_q <= 1'b1;
        end
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (state_q)
      ST_START: txd_o = 1'b0;
      ST_DATA:  txd_o = sh_q[0];
      ST_MPB:   txd_o = mpb_q;
      default:  txd_o = 1'b1;
    endcase
  end

  a_r2_bit_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !baud_tick_i |=> $stable(txd_o));
  a_r1_idle_mark: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> txd_o);
endmodule

// File: rtl/mptx_irq.sv
module mptx_irq (
  input  logic empty_i,
  input  logic tend_i,
  input  logic txi_en_i,
  input  logic tei_en_i,
  output logic txi_o,
  output logic tei_o
);
  assign txi_o = empty_i & txi_en_i;
  assign tei_o = tend_i & tei_en_i;
endmodule

// File: rtl/mptx_top.sv
module mptx_top #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              baud_tick_i,
  input  logic              seven_bit_i,
  input  logic              two_stop_i,
  input  logic              wr_data_i,
  input  logic [DATA_W-1:0] wr_byte_i,
  input  logic              wr_mpb_i,
  input  logic              clr_empty_i,
  input  logic              txi_en_i,
  input  logic              tei_en_i,
  output logic              txd_o,
  output logic              empty_o,
  output logic              tend_o,
  output logic              txi_o,
  output logic              tei_o
);
  logic              eff_empty;
  logic [DATA_W-1:0] fwd_byte;
  logic              fwd_mpb;
  logic              load;
  logic              miss;

  mptx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_data_i   (wr_data_i),
    .wr_byte_i   (wr_byte_i),
    .wr_mpb_i    (wr_mpb_i),
    .clr_empty_i (clr_empty_i),
    .load_i      (load),
    .miss_i      (miss),
    .eff_empty_o (eff_empty),
    .fwd_byte_o  (fwd_byte),
    .fwd_mpb_o   (fwd_mpb),
    .empty_o     (empty_o),
    .tend_o      (tend_o)
  );

  mptx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .baud_tick_i (baud_tick_i),
    .seven_bit_i (seven_bit_i),
    .two_stop_i  (two_stop_i),
    .eff_empty_i (eff_empty),
    .ld_byte_i   (fwd_byte),
    .ld_mpb_i    (fwd_mpb),
    .load_o      (load),
    .miss_o      (miss),
    .txd_o       (txd_o)
  );

  mptx_irq u_irq (
    .empty_i  (empty_o),
    .tend_i   (tend_o),
    .txi_en_i (txi_en_i),
    .tei_en_i (tei_en_i),
    .txi_o    (txi_o),
    .tei_o    (tei_o)
  );

  a_r10_tei_needs_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tei_o |-> tend_o);
endmodule

// File: tb/tb_mptx_top.sv
module tb_mptx_top;
  localparam int DATA_W = 8;
  localparam int TICKP  = 4;
  localparam int LOGN   = 8192;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              baud_tick = 1'b0;
  logic              seven = 1'b0;
  logic              two = 1'b0;
  logic              wr_data = 1'b0;
  logic [DATA_W-1:0] wr_byte = '0;
  logic              wr_mpb = 1'b0;
  logic              clr_empty = 1'b0;
  logic              txi_en = 1'b1;
  logic              tei_en = 1'b0;
  logic              txd_o, empty_o, tend_o, txi_o, tei_o;

  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done = 1'b0;
  logic bit_log [LOGN];
  int   nlog = 0;
  int   tcnt = 0;

  always #10 clk = ~clk;

  mptx_top #(.DATA_W(DATA_W)) dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .baud_tick_i (baud_tick),
    .seven_bit_i (seven),
    .two_stop_i  (two),
    .wr_data_i   (wr_data),
    .wr_byte_i   (wr_byte),
    .wr_mpb_i    (wr_mpb),
    .clr_empty_i (clr_empty),
    .txi_en_i    (txi_en),
    .tei_en_i    (tei_en),
    .txd_o       (txd_o),
    .empty_o     (empty_o),
    .tend_o      (tend_o),
    .txi_o       (txi_o),
    .tei_o       (tei_o)
  );

  // tick generator and line capture: one log entry per bit period
  always @(negedge clk) begin
    if (!rst_ni) begin
      tcnt      = 0;
      baud_tick = 1'b0;
    end else begin
      if (baud_tick && nlog < LOGN) begin
        bit_log[nlog] = txd_o;
        nlog++;
      end
      tcnt      = (tcnt + 1) % TICKP;
      baud_tick = (tcnt == 0);
    end
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
    end
  endtask

  task automatic write_reg(input logic [DATA_W-1:0] d, input logic m);
    @(negedge clk);
    wr_data = 1'b1; wr_byte = d; wr_mpb = m;
    @(negedge clk);
    wr_data = 1'b0;
  endtask

  task automatic send(input logic [DATA_W-1:0] d, input logic m, output int n_after);
    while (empty_o !== 1'b1) @(negedge clk);
    write_reg(d, m);
    @(negedge clk);
    clr_empty = 1'b1;
    @(negedge clk);
    clr_empty = 1'b0;
    #1;
    n_after = nlog;
  endtask

  task automatic check_frame(inout int p, input logic [7:0] d, input logic m,
                             input bit sev, input bit tws, input int gap_exp, input string rq);
    int gap;
    int len;
    int nb;
    logic [15:0] e;
    logic [15:0] a;
    gap = 0;
    nb  = sev ? 7 : 8;
    while (p < nlog && bit_log[p] === 1'b1) begin gap++; p++; end
    chk(gap == gap_exp, {rq, " gap"}, gap, gap_exp);
    e = '1; a = '1; len = 0;
    e[len] = 1'b0; len++;
    for (int i = 0; i < nb; i++) begin e[len] = d[i]; len++; end
    e[len] = m; len++;
    e[len] = 1'b1; len++;
    if (tws) begin e[len] = 1'b1; len++; end
    for (int i = 0; i < len; i++) begin
      a[i] = (p < nlog) ? bit_log[p] : 1'bx;
      p++;
    end
    chk(a === e, rq, int'(a), int'(e));
  endtask

  task automatic wait_end();
    while (tend_o !== 1'b1) @(negedge clk);
    repeat (4 * TICKP) @(negedge clk);
    #1;
  endtask

  initial begin
    logic [7:0] dv [64];
    logic       mv [64];
    int n0;
    int n;
    int p;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk); #1;
    chk(txd_o === 1'b1,   "R1 line at mark", txd_o, 1);
    chk(empty_o === 1'b1, "R1 empty flag set", empty_o, 1);
    chk(tend_o === 1'b1,  "R1 end flag set", tend_o, 1);
    chk(txi_o === 1'b1,   "R10 empty request", txi_o, 1);
    chk(tei_o === 1'b0,   "R10 end request masked", tei_o, 0);
    tei_en = 1'b1; #1;
    chk(tei_o === 1'b1,   "R10 end request enabled", tei_o, 1);
    repeat (3 * TICKP) @(negedge clk); #1;
    chk(nlog > 0 && bit_log[nlog-1] === 1'b1, "R1 idle line captured high", txd_o, 1);

    // sweep: every data value once across the four configurations
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      seven = c[0]; two = c[1];
      for (int i = 0; i < 64; i++) begin
        dv[i] = 8'(i * 4 + c);
        mv[i] = 1'(((i >> 1) ^ c) & 1);
      end
      n0 = 0;
      for (int i = 0; i < 64; i++) begin
        send(dv[i], mv[i], n);
        if (i == 0) begin
          n0 = n;
          chk(empty_o === 1'b1, "R5 empty set after load", empty_o, 1);
          chk(tend_o === 1'b0,  "R8 end flag cleared", tend_o, 0);
        end
      end
      wait_end();
      p = n0;
      for (int i = 0; i < 64; i++)
        check_frame(p, dv[i], mv[i], seven, two, 0,
                    $sformatf("R2 R5 R6 R9 %s %s cfg%0d frame%0d",
                              seven ? "R3" : "-", two ? "R4" : "-", c, i));
      n = p;
      while (p < nlog && bit_log[p] === 1'b1) p++;
      chk(p == nlog, "R7 mark after last frame", p - n, nlog - n);
    end

    // clear lands on the stop-bit check tick
    @(negedge clk);
    seven = 1'b0; two = 1'b0;
    send(8'hA5, 1'b1, n0);
    write_reg(8'h3C, 1'b0);
    chk(txi_o === 1'b1, "R10 empty request during frame", txi_o, 1);
    txi_en = 1'b0; #1;
    chk(txi_o === 1'b0, "R10 empty request masked", txi_o, 0);
    txi_en = 1'b1;
    do begin @(negedge clk); #1; end while (nlog < n0 + 10);
    repeat (3) @(negedge clk);
    clr_empty = 1'b1;
    @(negedge clk);
    clr_empty = 1'b0;
    #1;
    chk(tend_o === 1'b0,  "R6 coincident clear: no end flag", tend_o, 0);
    chk(empty_o === 1'b1, "R6 coincident clear: loaded", empty_o, 1);
    wait_end();
    p = n0;
    check_frame(p, 8'hA5, 1'b1, 1'b0, 1'b0, 0, "R9 R6 first frame");
    check_frame(p, 8'h3C, 1'b0, 1'b0, 1'b0, 0, "R6 chained frame");

    // clear one cycle after the check
    send(8'h96, 1'b0, n0);
    write_reg(8'h4B, 1'b1);
    do begin @(negedge clk); #1; end while (nlog < n0 + 10);
    repeat (4) @(negedge clk);
    #1;
    chk(tend_o === 1'b1, "R7 end flag at check", tend_o, 1);
    chk(tei_o === 1'b1,  "R10 end request level", tei_o, 1);
    tei_en = 1'b0; #1;
    chk(tei_o === 1'b0,  "R10 end request drops with enable", tei_o, 0);
    tei_en = 1'b1;
    clr_empty = 1'b1;
    @(negedge clk);
    clr_empty = 1'b0;
    #1;
    chk(tend_o === 1'b0,  "R8 clear drops end flag", tend_o, 0);
    chk(empty_o === 1'b0, "R7 no load during stop bit", empty_o, 0);
    chk(txi_o === 1'b0,   "R10 no empty request while data waits", txi_o, 0);
    wait_end();
    p = n0;
    check_frame(p, 8'h96, 1'b0, 1'b0, 1'b0, 0, "R7 frame before miss");
    check_frame(p, 8'h4B, 1'b1, 1'b0, 1'b0, 1, "R7 late frame one mark bit");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog R1-all act=%0d exp=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule